// File: doc/BRIEF.md
# Region-Based I/O Wait-State Generator

This block stretches accesses to a 2048-word peripheral I/O space. Each access arrives as a request with an 11-bit word address. The two top address bits choose one of four 512-word regions. Each region has its own 3-bit wait setting. One global mode bit decides how that setting turns into a number of wait cycles: either the setting itself (0 to 7), or twice the setting plus one (1 to 15). No external ready signal exists. The stretch comes only from these settings.

Once an access is accepted, the block holds an active-high strobe for one base cycle plus the computed wait cycles. It pulses a done flag in the last strobe cycle. Requests that arrive while an access is running are dropped. The settings are written through a small select/data port. A setting is captured when an access is accepted, so rewriting it during an access leaves that access unchanged. The data path and the logic that issues the reads and writes are outside this block.

Top module: `io_wait_gen`

## Requirements
- R1: The region is `io_addr[10:9]`: value 0 covers words 0x000–0x1FF, 1 covers 0x200–0x3FF, 2 covers 0x400–0x5FF and 3 covers 0x600–0x7FF. The wait setting of that region alone sets the access length.
- R2: With the mode bit at 0, the number of wait cycles N equals the region's 3-bit setting (0 to 7).
- R3: With the mode bit at 1, N equals twice the setting plus one. A setting of 0 gives 1 and a setting of 7 gives 15.
- R4: A request is taken at a rising edge while the block is idle. `io_strobe` is high from that edge for exactly 1+N consecutive cycles.
- R5: `io_done` is high for exactly one cycle per access: the last cycle in which `io_strobe` is high.
- R6: A request raised while `io_strobe` is high, including during the done cycle, is ignored. It neither lengthens the current access nor starts another one.
- R7: During and after reset, `io_strobe` and `io_done` are low, all four settings are 7 and the mode bit is 0. The first access to any region therefore lasts 8 cycles.
- R8: When `cfg_we` is high, `cfg_sel` selects the target: values 0–3 load `cfg_data` into the setting of the region with that number, and 4 loads `cfg_data[0]` into the mode bit. Values 5–7 change nothing. A write made during an access does not alter that access; it applies from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Access request, sampled while idle |
| io_addr | input | 11 | I/O word address of the request |
| io_strobe | output | 1 | Access strobe, held for 1+N cycles |
| io_done | output | 1 | One-cycle completion pulse in the last strobe cycle |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Configuration target: 0–3 region setting, 4 mode bit |
| cfg_data | input | 3 | Configuration write data |

## Verification
The bench probes the addresses on both sides of each region boundary. A decoder that used the wrong address bits would give a boundary word the wait length of its neighbour. Settings of 0 and 7 in both modes cover the shortest access (one cycle, strobe and done together) and the longest (sixteen cycles). A counter that is off by one, or a mode formula that drops the added one, shows up as a wrong strobe length.

Requests are injected in the middle of an access and during the done cycle. A sequencer that re-armed too early would extend the strobe or start a second access. A configuration write during an access checks that the wait count is captured at acceptance. Writes to unused select codes and to upper mode data bits check that only the named targets change.

// File: rtl/io_ws_pkg.sv
package io_ws_pkg;
  // Sequencer state: waiting for a request, or holding the strobe.
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_HOLD = 1'b1} seq_state_t;
endpackage

// File: rtl/io_ws_regs.sv
module io_ws_regs #(
  parameter int NREG      = 4,
  parameter int WREG_W    = 3,
  parameter int CFG_SEL_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [CFG_SEL_W-1:0]          sel,
  input  logic [WREG_W-1:0]             data,
  output logic [NREG-1:0][WREG_W-1:0]   wait_regs,
  output logic                          mode
);
  localparam logic [CFG_SEL_W-1:0] MODE_SEL = CFG_SEL_W'(NREG);
  localparam logic [WREG_W-1:0]    WREG_RST = '1;

  // Named write strobes, one per target.
  logic [NREG-1:0] reg_hit;
  logic            mode_hit;

  assign mode_hit = we && (sel == MODE_SEL);

  for (genvar g = 0; g < NREG; g++) begin : g_wreg
    assign reg_hit[g] = we && (sel == CFG_SEL_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)          wait_regs[g] <= WREG_RST;
      else if (reg_hit[g]) wait_regs[g] <= data;
    end

    // R8: a setting changes only when its own select code is written
    a_r8_reg_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && sel == CFG_SEL_W'(g)) |=> wait_regs[g] == $past(wait_regs[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        mode <= 1'b0;
    else if (mode_hit) mode <= data[0];
  end

  // R8: the mode bit changes only through its own select code
  a_r8_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && sel == MODE_SEL) |=> mode == $past(mode));
endmodule

// File: rtl/io_ws_decode.sv
module io_ws_decode #(
  parameter int NREG     = 4,
  parameter int WREG_W   = 3,
  parameter int SPACE_AW = 11,
  parameter int CNT_W    = WREG_W + 1
) (
  input  logic [SPACE_AW-1:0]           addr,
  input  logic [NREG-1:0][WREG_W-1:0]   wait_regs,
  input  logic                          mode,
  output logic [CNT_W-1:0]              wait_n
);
  localparam int REG_SEL_W = $clog2(NREG);

  // Wait count from a setting: the setting itself, or 2*setting+1 in wide mode.
  function automatic logic [CNT_W-1:0] wait_from_setting(
    input logic m, input logic [WREG_W-1:0] w);
    if (m) wait_from_setting = {w, 1'b1};
    else   wait_from_setting = {1'b0, w};
  endfunction

  logic [REG_SEL_W-1:0] region;
  logic [WREG_W-1:0]    setting;

  assign region  = addr[SPACE_AW-1 -: REG_SEL_W];
  assign setting = wait_regs[region];
  assign wait_n  = wait_from_setting(mode, setting);

  // R3: in wide mode the count is always odd
  always_comb begin
    if (mode) a_r3_odd_count: assert (wait_n[0] == 1'b1);
  end
endmodule

// File: rtl/io_ws_seq.sv
module io_ws_seq
  import io_ws_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CNT_W-1:0] wait_n,
  output logic             strobe,
  output logic             done
);
  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             accept;   // request taken this cycle
  logic             last;     // final strobe cycle

  assign accept = req && (state == SEQ_IDLE);
  assign strobe = (state == SEQ_HOLD);
  assign last   = (cnt == '0);
  assign done   = strobe && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (accept) begin
          state <= SEQ_HOLD;
          cnt   <= wait_n;
        end
        SEQ_HOLD: begin
          if (last) state <= SEQ_IDLE;
          else      cnt   <= cnt - 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R4: an accepted request raises the strobe with the region's count loaded
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> strobe && cnt == $past(wait_n));
  // R6: while busy the counter only steps down, whatever the request input does
  a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !done) |=> strobe && cnt == CNT_W'($past(cnt) - 1'b1));
  // R5: done is followed by an idle cycle, so it is a single pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !strobe && !done);
  // R4: the strobe never drops without a done in its last cycle
  a_r4_end_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> $past(done));
endmodule

// File: rtl/io_wait_gen.sv
module io_wait_gen #(
  parameter int SPACE_AW  = 11,
  parameter int NREG      = 4,
  parameter int WREG_W    = 3,
  parameter int CFG_SEL_W = $clog2(NREG + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 io_req,
  input  logic [SPACE_AW-1:0]  io_addr,
  output logic                 io_strobe,
  output logic                 io_done,
  input  logic                 cfg_we,
  input  logic [CFG_SEL_W-1:0] cfg_sel,
  input  logic [WREG_W-1:0]    cfg_data
);
  localparam int CNT_W = WREG_W + 1;

  logic [NREG-1:0][WREG_W-1:0] wait_regs;
  logic                        mode;
  logic [CNT_W-1:0]            wait_n;

  io_ws_regs #(.NREG(NREG), .WREG_W(WREG_W), .CFG_SEL_W(CFG_SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .data(cfg_data),
    .wait_regs(wait_regs), .mode(mode));

  io_ws_decode #(.NREG(NREG), .WREG_W(WREG_W), .SPACE_AW(SPACE_AW), .CNT_W(CNT_W)) u_dec (
    .addr(io_addr), .wait_regs(wait_regs), .mode(mode), .wait_n(wait_n));

  io_ws_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(io_req), .wait_n(wait_n),
    .strobe(io_strobe), .done(io_done));

  // R7: nothing is active in the cycle after reset
  a_r7_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> !io_strobe && !io_done);
endmodule

// File: tb/sim_io_wait_gen.sv
module sim_io_wait_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req = 1'b0;
  logic [10:0] io_addr = '0;
  logic        io_strobe, io_done;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [2:0]  cfg_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  io_wait_gen u0 (.*);

  // {mode, base setting, address}; region k is programmed to (base+k) mod 8
  localparam int NVEC = 11;
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 11'h000}, {1'b0, 3'd5, 11'h1FF}, {1'b0, 3'd2, 11'h200},
    {1'b1, 3'd1, 11'h3FF}, {1'b1, 3'd6, 11'h400}, {1'b1, 3'd7, 11'h5FF},
    {1'b0, 3'd4, 11'h600}, {1'b1, 3'd0, 11'h7FF}, {1'b0, 3'd1, 11'h205},
    {1'b1, 3'd5, 11'h6A0}, {1'b1, 3'd7, 11'h0C3}};

  function automatic int exp_len(input bit m, input int w);
    int waits;
    waits = m ? (w + w + 1) : w;
    return waits + 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] s, input logic [2:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // poke: 0 none, 1 request in 2nd strobe cycle, 2 request in done cycle,
  //       3 write region 0 setting to 0 in 2nd strobe cycle
  task automatic run_access(input logic [10:0] a, input int poke,
                            output int len, output int nd, output int last_done);
    len = 0; nd = 0; last_done = -1;
    @(negedge clk);
    io_req = 1'b1; io_addr = a;
    @(negedge clk);
    io_req = 1'b0;
    while (io_strobe && len < 40) begin
      len++;
      if (io_done) begin nd++; last_done = len; end
      io_req = 1'b0; cfg_we = 1'b0;
      if (poke == 1 && len == 2) io_req = 1'b1;
      if (poke == 2 && io_done) io_req = 1'b1;
      if (poke == 3 && len == 2) begin cfg_we = 1'b1; cfg_sel = 3'd0; cfg_data = 3'd0; end
      @(negedge clk);
    end
    io_req = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic access_check(input logic [10:0] a, input int exp, input string tag);
    int len, nd, ld;
    run_access(a, 0, len, nd, ld);
    chk(len == exp, {tag, " strobe length"}, len, exp);
    chk(nd == 1, "R5 done count", nd, 1);
    chk(ld == len, "R5 done in last strobe cycle", ld, len);
  endtask

  initial begin
    int len, nd, ld;
    // R7: outputs quiet while reset is held
    repeat (3) @(negedge clk);
    chk(io_strobe == 1'b0, "R7 strobe in reset", io_strobe, 0);
    chk(io_done == 1'b0, "R7 done in reset", io_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(io_strobe == 1'b0, "R7 strobe after reset", io_strobe, 0);
    // R7: default settings 7, mode 0 -> 8 cycles in every region
    for (int r = 0; r < 4; r++) access_check(11'(r * 512 + 17), 8, "R7 default");

    // Vector table: R1 region decode, R2/R3 count formula, R4 length, R5 done
    for (int v = 0; v < NVEC; v++) begin
      logic m; logic [2:0] b; logic [10:0] a; int w;
      {m, b, a} = VEC[v];
      for (int k = 0; k < 4; k++) cfg_write(3'(k), 3'(b + 3'(k)));
      cfg_write(3'd4, {2'b00, m});
      w = int'(3'(b + 3'(a[10:9])));
      access_check(a, exp_len(m, w), m ? "R1/R3" : "R1/R2");
    end

    // R6: request in the middle of an access, then in the done cycle
    for (int k = 0; k < 4; k++) cfg_write(3'(k), 3'd7);
    cfg_write(3'd4, 3'd0);
    for (int p = 1; p <= 2; p++) begin
      run_access(11'h123, p, len, nd, ld);
      chk(len == 8, "R6 length with stray request", len, 8);
      chk(nd == 1, "R6 single done", nd, 1);
      for (int i = 0; i < 3; i++) begin
        chk(io_strobe == 1'b0, "R6 no second access", io_strobe, 0);
        @(negedge clk);
      end
    end

    // R8: write during an access leaves it alone, applies to the next one
    run_access(11'h010, 3, len, nd, ld);
    chk(len == 8, "R8 current access unchanged", len, 8);
    access_check(11'h010, 1, "R8 new setting applied");

    // R8: unused select codes change nothing
    cfg_write(3'd0, 3'd3);
    for (int s = 5; s < 8; s++) cfg_write(3'(s), 3'd0);
    access_check(11'h000, 4, "R8 sel 5-7 ignored (region 0)");
    access_check(11'h7FF, 8, "R8 sel 5-7 ignored (region 3)");
    // R8: only data bit 0 reaches the mode bit
    cfg_write(3'd4, 3'b110);
    access_check(11'h000, 4, "R8 mode from data bit 0");
    cfg_write(3'd4, 3'b001);
    access_check(11'h000, 8, "R3 mode set, setting 3");

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule